// File: doc/BRIEF.md
# Split-Mode Dual 8-Bit Timer with Overflow Toggle Pins

This block holds a timer arranged as two independent 8-bit up-counters that share one clock prescaler. The low channel counts either prescaler ticks or falling edges on its pad input. It advances only while its run bit is set. When gating is on, an external gate pin must also be high for it to advance. The high channel counts only prescaler ticks and has its own run bit. Each channel wraps from 0xFF to 0x00, raises a sticky overflow flag and can drive a toggle output on the pad it shares with its count input.

Each toggle output is a small state machine with three states. In `TGL_OFF` the enable is clear and the pad is released high. In `TGL_HOLD` the pad is driven high and waits for the first overflow. In `TGL_LOW` the pad is driven low. These are the transitions: any state goes to `TGL_OFF` when the enable clears; `TGL_OFF` goes to `TGL_HOLD` when the enable sets; `TGL_HOLD` goes to `TGL_LOW` on overflow; `TGL_LOW` goes back to `TGL_HOLD` on overflow. The pad-edge sampler has two states. In `SMP_LOW` it waits for a high sample. In `SMP_HIGH` it is armed, and a low sample returns it to `SMP_LOW` and produces one count pulse.

Top module: `split_timer`

## Requirements
- R1: During and right after reset both counts are 0, both flags are 0 and both pad outputs are 1.
- R2: The prescaler ticks once every 6 clocks when `div_sel`=0 and once every 12 clocks when `div_sel`=1. The first tick is on the 6th (or 12th) rising edge after reset is released. A running channel in timer mode advances by one on each tick.
- R3: When `lo_src_ext`=1 the low channel counts 1-to-0 transitions of `lo_pad_in`. The pad is registered once. An edge counts at the second rising clock edge after the pad falls, and only after the pad has been sampled high at least once. Each edge counts exactly once.
- R4: A channel whose run bit is 0 holds its count.
- R5: When `lo_gate_en`=1 the low channel advances only while `gate_pin`=1. When `lo_gate_en`=0, `gate_pin` has no effect.
- R6: A wrap from 0xFF to 0x00 sets that channel's flag on the same clock edge. The flag stays set until a clear pulse. A wrap on the same edge as a clear leaves the flag set.
- R7: With the output enable at 0 the pad output is 1. On the first edge with the enable at 1 the pad is held at 1, even if an overflow occurs on that edge. After that the pad inverts on every overflow of its own channel. Clearing the enable returns the pad to 1, and re-enabling starts again at 1.
- R8: While a channel is stopped, its pad output keeps its level.
- R9: The high channel ignores `lo_src_ext`, `lo_gate_en` and `gate_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | Prescaler select: 0 divides by 6, 1 divides by 12 |
| lo_run | input | 1 | Low channel run bit |
| lo_src_ext | input | 1 | Low channel source: 0 prescaler ticks, 1 pad falling edges |
| lo_gate_en | input | 1 | Low channel gating enable |
| gate_pin | input | 1 | External gate level |
| lo_pad_in | input | 1 | Low channel pad, input side |
| lo_oe | input | 1 | Low channel toggle output enable |
| lo_flag_clr | input | 1 | Clears the low overflow flag |
| hi_run | input | 1 | High channel run bit |
| hi_oe | input | 1 | High channel toggle output enable |
| hi_flag_clr | input | 1 | Clears the high overflow flag |
| lo_count | output | 8 | Low channel count |
| hi_count | output | 8 | High channel count |
| lo_flag | output | 1 | Low channel overflow flag |
| hi_flag | output | 1 | High channel overflow flag |
| lo_pad_out | output | 1 | Low channel pad, output side |
| hi_pad_out | output | 1 | High channel pad, output side |

## Verification
A timer tick, a run or gate change, a flag clear and an enable change each act on the next rising edge. A pad fall reaches the low count on the second rising edge after it, because of the sample register. A wrap changes the count, the flag and the pad together on one edge. The bench drives inputs and samples outputs at the falling edge. Its reference model advances exactly one step per rising edge from the inputs that edge sees, so every comparison lands in the cycle its result is due. The directed counts (10 ticks in 60 or 120 clocks, the 256th tick on clock 1536) were worked out by hand from those latencies.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        TGL_OFF  = 2'd0,
        TGL_HOLD = 2'd1,
        TGL_LOW  = 2'd2
    } tgl_state_t;

    typedef enum logic {
        SMP_LOW  = 1'b0,
        SMP_HIGH = 1'b1
    } smp_state_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_A = 6,
    parameter int DIV_B = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic tick
);
    localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int PW      = $clog2(DIV_MAX);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim  = sel ? PW'(DIV_B - 1) : PW'(DIV_A - 1);
        // >= so that a switch to the shorter divide wraps at once
        tick = (cnt_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/fall_detector.sv
module fall_detector
    import split_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic fall
);
    logic       smp_q;
    smp_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_LOW:  if (smp_q)  state_d = SMP_HIGH;
            SMP_HIGH: if (!smp_q) state_d = SMP_LOW;
            default:  state_d = SMP_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q   <= 1'b0;
            state_q <= SMP_LOW;
        end else begin
            smp_q   <= pad;
            state_q <= state_d;
        end
    end

    always_comb fall = (state_q == SMP_HIGH) && !smp_q;
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] count,
    output logic             flag,
    output logic             wrap
);
    always_comb wrap = inc && (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else begin
            if (inc) count <= count + 1'b1;
            if (wrap)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/toggle_pin.sv
module toggle_pin
    import split_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe,
    input  logic wrap,
    output logic pad_out
);
    tgl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!oe) begin
            state_d = TGL_OFF;
        end else begin
            unique case (state_q)
                TGL_OFF:  state_d = TGL_HOLD;
                TGL_HOLD: if (wrap) state_d = TGL_LOW;
                TGL_LOW:  if (wrap) state_d = TGL_HOLD;
                default:  state_d = TGL_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TGL_OFF;
        else        state_q <= state_d;
    end

    always_comb pad_out = (state_q != TGL_LOW);
endmodule

// File: rtl/split_timer.sv
module split_timer
    import split_timer_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DIV_A = 6,
    parameter int DIV_B = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_sel,
    input  logic             lo_run,
    input  logic             lo_src_ext,
    input  logic             lo_gate_en,
    input  logic             gate_pin,
    input  logic             lo_pad_in,
    input  logic             lo_oe,
    input  logic             lo_flag_clr,
    input  logic             hi_run,
    input  logic             hi_oe,
    input  logic             hi_flag_clr,
    output logic [WIDTH-1:0] lo_count,
    output logic [WIDTH-1:0] hi_count,
    output logic             lo_flag,
    output logic             hi_flag,
    output logic             lo_pad_out,
    output logic             hi_pad_out
);
    logic tick;
    logic pad_fall;
    logic [NUM_CH-1:0] inc_v, clr_v, oe_v, wrap_v, flag_v, pin_v;
    logic [WIDTH-1:0]  cnt_v [NUM_CH];

    tick_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) pre_i (
        .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(tick)
    );

    fall_detector fall_i (
        .clk(clk), .rst_n(rst_n), .pad(lo_pad_in), .fall(pad_fall)
    );

    always_comb begin
        inc_v[0] = lo_run && (!lo_gate_en || gate_pin) && (lo_src_ext ? pad_fall : tick);
        inc_v[1] = hi_run && tick;
        clr_v    = {hi_flag_clr, lo_flag_clr};
        oe_v     = {hi_oe, lo_oe};
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        wrap_counter #(.WIDTH(WIDTH)) cnt_i (
            .clk(clk), .rst_n(rst_n), .inc(inc_v[ch]), .flag_clr(clr_v[ch]),
            .count(cnt_v[ch]), .flag(flag_v[ch]), .wrap(wrap_v[ch])
        );
        toggle_pin tgl_i (
            .clk(clk), .rst_n(rst_n), .oe(oe_v[ch]), .wrap(wrap_v[ch]),
            .pad_out(pin_v[ch])
        );
    end

    always_comb begin
        lo_count   = cnt_v[0];
        hi_count   = cnt_v[1];
        lo_flag    = flag_v[0];
        hi_flag    = flag_v[1];
        lo_pad_out = pin_v[0];
        hi_pad_out = pin_v[1];
    end
endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lo_run,
    input logic             lo_gate_en,
    input logic             gate_pin,
    input logic             lo_flag_clr,
    input logic             hi_run,
    input logic             hi_oe,
    input logic             hi_flag_clr,
    input logic [WIDTH-1:0] lo_count,
    input logic [WIDTH-1:0] hi_count,
    input logic             lo_flag,
    input logic             hi_flag,
    input logic             lo_pad_out,
    input logic             hi_pad_out
);
    AST_LO_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_run |=> $stable(lo_count)); // R4
    AST_HI_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_run |=> $stable(hi_count)); // R4
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_gate_en && !gate_pin) |=> $stable(lo_count)); // R5
    AST_LO_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_count == '0 && $past(lo_count) == '1) |-> lo_flag); // R6
    AST_HI_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_count == '0 && $past(hi_count) == '1) |-> hi_flag); // R6
    AST_LO_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_flag && !lo_flag_clr) |=> lo_flag); // R6
    AST_HI_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_flag && !hi_flag_clr) |=> hi_flag); // R6
    AST_HI_PAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_oe |=> hi_pad_out); // R7
    AST_HI_PAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_run && hi_oe) |=> $stable(hi_pad_out)); // R8
    AST_RESET_PADS: assert property (@(posedge clk)
        !rst_n |-> (lo_pad_out && hi_pad_out)); // R1
endmodule

bind split_timer split_timer_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/split_timer_tb_top.sv
module split_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_sel = 0, lo_run = 0, lo_src_ext = 0, lo_gate_en = 0, gate_pin = 0;
    logic lo_pad_in = 0, lo_oe = 0, lo_flag_clr = 0, hi_run = 0, hi_oe = 0, hi_flag_clr = 0;
    logic [7:0] lo_count, hi_count;
    logic lo_flag, hi_flag, lo_pad_out, hi_pad_out;

    always #2 clk = ~clk;

    split_timer dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state (one step per rising edge)
    int m_pre, m_lt, m_ht;
    logic [7:0] m_lo, m_hi;
    bit m_lf, m_hf, m_s1, m_seen;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tgl_next(bit oe, int st, bit wrap);
        if (!oe) return 0;
        if (st == 0) return 1;
        if (wrap) return (st == 1) ? 2 : 1;
        return st;
    endfunction

    task automatic model_reset();
        m_pre = 0; m_lt = 0; m_ht = 0; m_lo = 0; m_hi = 0;
        m_lf = 0; m_hf = 0; m_s1 = 0; m_seen = 0;
    endtask

    task automatic model_step();
        int lim = div_sel ? 12 : 6;
        bit tick = (m_pre >= lim - 1);
        bit fall = m_seen && !m_s1;
        bit li = lo_run && (!lo_gate_en || gate_pin) && (lo_src_ext ? fall : tick);
        bit hinc = hi_run && tick;
        bit lw = li && (m_lo == 8'hFF);
        bit hw = hinc && (m_hi == 8'hFF);
        m_lf = lw | (m_lf & !lo_flag_clr);
        m_hf = hw | (m_hf & !hi_flag_clr);
        m_lt = tgl_next(lo_oe, m_lt, lw);
        m_ht = tgl_next(hi_oe, m_ht, hw);
        if (li) m_lo = m_lo + 8'd1;
        if (hinc) m_hi = m_hi + 8'd1;
        if (m_seen && !m_s1) m_seen = 0;
        else if (!m_seen && m_s1) m_seen = 1;
        m_s1 = lo_pad_in;
        m_pre = tick ? 0 : m_pre + 1;
    endtask

    task automatic compare_all();
        chk("R3 lo_count", lo_count, m_lo);
        chk("R2 hi_count", hi_count, m_hi);
        chk("R6 lo_flag", lo_flag, m_lf);
        chk("R6 hi_flag", hi_flag, m_hf);
        chk("R7 lo_pad_out", lo_pad_out, m_lt != 2);
        chk("R7 hi_pad_out", hi_pad_out, m_ht != 2);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic do_reset();
        {div_sel, lo_run, lo_src_ext, lo_gate_en, gate_pin} = '0;
        {lo_pad_in, lo_oe, lo_flag_clr, hi_run, hi_oe, hi_flag_clr} = '0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1;
    endtask

    initial begin
        int seed = $urandom(32'd20240611);
        do_reset();
        // R1 reset state
        chk("R1 lo_count", lo_count, 0);
        chk("R1 hi_count", hi_count, 0);
        chk("R1 flags", {lo_flag, hi_flag}, 0);
        chk("R1 pads", {lo_pad_out, hi_pad_out}, 3);

        // R2 divide by 6 and by 12
        div_sel = 0; hi_run = 1; lo_run = 1;
        step(60);
        chk("R2 hi div6", hi_count, 10);
        chk("R2 lo div6", lo_count, 10);
        do_reset();
        div_sel = 1; hi_run = 1;
        step(120);
        chk("R2 hi div12", hi_count, 10);

        // R9 high channel ignores source and gate
        do_reset();
        hi_run = 1; lo_run = 1; lo_src_ext = 1; lo_gate_en = 1; gate_pin = 0; lo_pad_in = 1;
        step(60);
        chk("R9 hi unaffected", hi_count, 10);
        chk("R9 lo no edges", lo_count, 0);

        // R5 gating
        do_reset();
        lo_run = 1; lo_gate_en = 1; gate_pin = 0;
        step(60);
        chk("R5 gated low", lo_count, 0);
        gate_pin = 1;
        step(60);
        chk("R5 gate open", lo_count, 10);

        // R3 pad edges, R4 stop
        do_reset();
        lo_run = 1; lo_src_ext = 1;
        for (int k = 0; k < 20; k++) begin
            lo_pad_in = 1; step(2);
            lo_pad_in = 0; step(2);
        end
        step(2);
        chk("R3 edge count", lo_count, 20);
        lo_run = 0;
        for (int k = 0; k < 5; k++) begin
            lo_pad_in = 1; step(2);
            lo_pad_in = 0; step(2);
        end
        chk("R4 stopped low", lo_count, 20);

        // R6 / R7 / R8 high channel wrap
        do_reset();
        hi_run = 1; hi_oe = 1;
        step(1535);
        chk("R7 pad before wrap", hi_pad_out, 1);
        chk("R6 count before wrap", hi_count, 255);
        chk("R6 flag before wrap", hi_flag, 0);
        step(1);
        chk("R6 wrap count", hi_count, 0);
        chk("R6 wrap flag", hi_flag, 1);
        chk("R7 pad toggled", hi_pad_out, 0);
        hi_run = 0;
        step(50);
        chk("R6 flag sticky", hi_flag, 1);
        chk("R8 pad held", hi_pad_out, 0);
        hi_flag_clr = 1; step(1); hi_flag_clr = 0;
        chk("R6 flag cleared", hi_flag, 0);
        hi_oe = 0; step(1);
        chk("R7 pad released", hi_pad_out, 1);
        hi_oe = 1; step(1);
        chk("R7 re-enable high", hi_pad_out, 1);

        // constrained random phases against the model
        for (int ph = 0; ph < 12; ph++) begin
            for (int c = 0; c < 1500; c++) begin
                if (c % 97 == 0) begin
                    div_sel = $urandom_range(0, 1); lo_run = ($urandom_range(0, 7) != 0);
                    lo_src_ext = $urandom_range(0, 1); lo_gate_en = $urandom_range(0, 1);
                    lo_oe = ($urandom_range(0, 5) != 0); hi_run = ($urandom_range(0, 7) != 0);
                    hi_oe = ($urandom_range(0, 5) != 0);
                end
                if ($urandom_range(0, 2) == 0) lo_pad_in = ~lo_pad_in;
                if ($urandom_range(0, 7) == 0) gate_pin = ~gate_pin;
                lo_flag_clr = ($urandom_range(0, 63) == 0);
                hi_flag_clr = ($urandom_range(0, 63) == 0);
                step(1);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule